// File: doc/BRIEF.md
# Carry-Chain Wide Reduction Unit

This block reduces a wide input vector to one bit, either as the AND of all its bits or as the OR of all its bits. A mode input picks which one. The reduction does not use a logarithmic gate tree. The vector is cut into K-bit chunks, and small logic stands in for a K-input lookup table to reduce each chunk to one bit. Those chunk bits then feed a ripple chain of carry cells. The chain works like adding one to the vector of chunk bits: the carry-in is held at 1, and the carry that leaves the top cell is the answer.

In OR mode each chunk produces the NOR of its bits, so the carry that leaves the chain means "every input bit is zero". That value is inverted to give the OR. An elaboration parameter adds one output register, which is on by default. The register is cleared by the asynchronous active-low reset. With the register off, the output is purely combinational.

Top module: `wide_reduce`

## Requirements
- R1: With mode_i = 0 (AND mode), the result equals the AND of all N bits of data_i.
- R2: With mode_i = 1 (OR mode), the result equals the OR of all N bits of data_i.
- R3: The chain has ceil(N/K) cells with carry-in 1. Each cell's carry-out is the AND of its propagate and its carry-in. A cell's propagate is the AND (AND mode) or the NOR (OR mode) of one K-bit chunk. The final carry is 1 exactly when every propagate is 1.
- R4: When N is not a multiple of K, the unused upper bits of the top chunk are filled with 1 in AND mode and 0 in OR mode, so the result depends only on the N real bits. This includes bit N-1, which lies alone in the top chunk at the default sizes.
- R5: In OR mode the output is the inverse of the all-zero indication taken from the chain's final carry.
- R6: With REG_OUT = 1, result_o shows the reduction of the data_i and mode_i values sampled at the previous rising clock edge.
- R7: While rst_ni is low, result_o is 0, and this takes effect without waiting for a clock edge.
- R8: A single differing bit decides the result at every position. All-ones with any one bit cleared gives 0 in AND mode. All-zeros with any one bit set gives 1 in OR mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset, clears result_o |
| data_i | input | N | Vector to reduce |
| mode_i | input | 1 | 0 selects AND reduction, 1 selects OR reduction |
| result_o | output | 1 | Reduction result |

## Verification
With the default registered output, each result is due one rising edge after its operands are applied. The bench changes data_i and mode_i on a falling edge and compares result_o on the next falling edge against a counting model of the operands it applied. Reset is the one exception, because it acts at once: the bench drops rst_ni between edges and checks result_o a nanosecond later, before any clock edge arrives. The corner patterns walk a single odd bit through every position, including the lone bit in the padded top chunk.

// File: rtl/wide_reduce_pkg.sv
package wide_reduce_pkg;
  typedef enum logic {
    MODE_AND = 1'b0,
    MODE_OR  = 1'b1
  } red_mode_e;

  function automatic int num_chunks(input int n, input int k);
    return (n + k - 1) / k;
  endfunction
endpackage

// File: rtl/wr_chunk_lut.sv
module wr_chunk_lut
  import wide_reduce_pkg::*;
#(
  parameter int K = 4
) (
  input  logic [K-1:0] bits_i,
  input  logic         mode_i,
  output logic         prop_o
);
  // stands in for one K-input LUT ahead of the carry cell
  always_comb begin
    if (red_mode_e'(mode_i) == MODE_OR) prop_o = ~(|bits_i);
    else                                prop_o = &bits_i;
  end
endmodule

// File: rtl/wr_carry_cell.sv
module wr_carry_cell (
  input  logic prop_i,
  input  logic carry_i,
  output logic carry_o
);
  // addend is zero apart from carry-in: no generate term
  assign carry_o = prop_i & carry_i;
endmodule

// File: rtl/wide_reduce.sv
module wide_reduce
  import wide_reduce_pkg::*;
#(
  parameter int N       = 37,
  parameter int K       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] data_i,
  input  logic         mode_i,
  output logic         result_o
);
  localparam int C = num_chunks(N, K);
  localparam int W = C * K;

  initial begin
    if (N < 1)          $error("N must be at least 1");
    if (K < 2 || K > 6) $error("K must lie in 2..6");
  end

  logic         pad_bit;
  logic [W-1:0] padded;
  logic [C-1:0] prop;
  logic [C:0]   carry;
  logic         raw;

  // pad so spare bits never change the result
  assign pad_bit = (red_mode_e'(mode_i) == MODE_OR) ? 1'b0 : 1'b1;

  always_comb begin
    padded         = {W{pad_bit}};
    padded[N-1:0]  = data_i;
  end

  assign carry[0] = 1'b1;

  for (genvar c = 0; c < C; c++) begin : g_chain
    wr_chunk_lut #(.K(K)) u_lut (
      .bits_i (padded[c*K +: K]),
      .mode_i (mode_i),
      .prop_o (prop[c])
    );
    wr_carry_cell u_cell (
      .prop_i  (prop[c]),
      .carry_i (carry[c]),
      .carry_o (carry[c+1])
    );
  end

  assign raw = (red_mode_e'(mode_i) == MODE_OR) ? ~carry[C] : carry[C];

  if (REG_OUT) begin : g_reg
    logic res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= 1'b0;
      else         res_q <= raw;
    end
    assign result_o = res_q;

    a_r6_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (result_o == $past(mode_i ? (|data_i) : (&data_i))));
  end else begin : g_comb
    assign result_o = raw;
  end

  a_r1_and_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 1'b0) |-> (raw == (&data_i)));

  a_r2_or_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 1'b1) |-> (raw == (|data_i)));

  a_r3_chain_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry[C] == (&prop));

  a_r5_or_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 1'b1) |-> (carry[C] == (data_i == '0)));
endmodule

// File: tb/wide_reduce_test.sv
module wide_reduce_test;
  localparam int N = 37;
  localparam int K = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] data_i = '0;
  logic         mode_i = 1'b0;
  logic         result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wide_reduce #(.N(N), .K(K), .REG_OUT(1'b1)) uut (
    .clk_i, .rst_ni, .data_i, .mode_i, .result_o
  );

  always #10 clk_i = ~clk_i;

  function automatic logic ref_reduce(input logic [N-1:0] d, input logic m);
    int ones = 0;
    for (int b = 0; b < N; b++) if (d[b]) ones++;
    return m ? (ones > 0) : (ones == N);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: result_o=%b expected=%b data=%h mode=%b", req, act, exp, data_i, mode_i);
    end
  endtask

  // drive at falling edge, due one rising edge later
  task automatic apply(input string req, input logic [N-1:0] d, input logic m);
    @(negedge clk_i);
    data_i = d;
    mode_i = m;
    @(negedge clk_i);
    check(req, result_o, ref_reduce(d, m));
  endtask

  initial begin
    #1 check("R7", result_o, 1'b0);
    data_i = '1;
    repeat (2) @(negedge clk_i);
    check("R7", result_o, 1'b0);
    rst_ni = 1'b1;

    apply("R1", '1, 1'b0);
    apply("R1", '0, 1'b0);
    apply("R2", '0, 1'b1);
    apply("R2", '1, 1'b1);
    apply("R4", {1'b1, {(N-1){1'b0}}}, 1'b1);
    apply("R4", {1'b0, {(N-1){1'b1}}}, 1'b0);
    apply("R5", {{(N-1){1'b0}}, 1'b1}, 1'b1);

    for (int p = 0; p < N; p++) begin
      logic [N-1:0] v;
      v = '1; v[p] = 1'b0;
      apply("R8", v, 1'b0);
      v = '0; v[p] = 1'b1;
      apply("R8", v, 1'b1);
    end

    for (int i = 0; i < 300; i++) begin
      logic [N-1:0] v;
      int dens;
      dens = $urandom_range(0, 3);
      for (int b = 0; b < N; b++)
        v[b] = (dens == 0) ? 1'b1 : (dens == 3) ? 1'b0 : 1'($urandom_range(0, 1));
      apply((i % 2 == 0) ? "R1" : "R2", v, 1'(i % 2));
    end

    // back-to-back mode toggling on one vector (R3 chain per mode)
    for (int i = 0; i < 8; i++) apply("R3", 37'h0000F00000, 1'(i % 2));

    // asynchronous reset mid-run
    apply("R6", '1, 1'b0);
    check("R6", result_o, 1'b1);
    #3 rst_ni = 1'b0;
    #1 check("R7", result_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply("R6", '1, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule